// File: doc/BRIEF.md
# Code Lump Load Sequencer

This block runs the load of an executable code lump that is named by a capability word. When it gets a start pulse, it stores the capability and checks two things: that the capability type is the "inform" type, and that the execute permission is present. If both checks pass, it hands the word to an external namespace integrity gate through a start/done/fault handshake. After the gate succeeds, the block reads the lump header word at the entry base that the gate returned. It decodes the lump size and the c-list count from that header and checks that they are consistent.

From the header it derives two capabilities and writes them on consecutive cycles. The first is an execute-only code capability for register 14. The second is a c-list capability for register 6. The block signals done once both writes have happened. Any failed check, and any fault the gate reports, ends the load with a single fault pulse and a fault code. The block shares a memory read port with the gate and only drives it while the gate reports that it is not busy.

Top module: `lump_loader`

## Requirements
- R1: After reset, gateStart, memRdEn, regWrEn, loadDone and loadFault are all low and faultCode is 0.
- R2: A capability whose type field (bits 31:28) is not 5 ends the load with loadFault and faultCode 1, and gateStart never rises.
- R3: A capability of type 5 whose execute permission (bit 27) is 0 ends the load with loadFault and faultCode 2, and gateStart never rises.
- R4: For a valid capability, gateStart is high for exactly one cycle, two cycles after the start pulse is sampled, and gateCap then equals the capability word that was latched at start.
- R5: A gate fault ends the load with loadFault and faultCode equal to 4 plus the gate's 2-bit fault type, and no memory read is issued.
- R6: The single header read drives memRdEn with memAddr equal to the entry base that was latched on gateDone, and only in a cycle where gateBusy is low.
- R7: The header word holds the lump size in bits 15:0, the c-list count cc in bits 23:16, and a field in bits 31:24 that this block does not use. Register 14 is written with regWrKind 01 (execute-only), base = entry base + 4, and limit = lump size - cc - 2.
- R8: In the cycle right after the register 14 write, register 6 is written with regWrKind 10 (c-list), base = entry base + (lump size - cc) * 4, and limit = cc - 1. Addresses wrap modulo 2^32.
- R9: loadDone is high for one cycle in the cycle after the register 6 write, faultCode stays 0, and the block is idle in the next cycle.
- R10: A header with cc = 0, or with cc greater than lump size - 2, ends the load with loadFault and faultCode 3 and no register write.
- R11: A start pulse that arrives while a load is in progress is ignored.
- R12: loadDone and loadFault are never high together, and each lasts for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a load when idle |
| capWord | input | 32 | Capability word sampled with startPulse |
| gateStart | output | 1 | One-cycle start to the integrity gate |
| gateCap | output | 32 | Latched capability word given to the gate |
| gateDone | input | 1 | Gate success pulse |
| gateFault | input | 1 | Gate failure pulse |
| gateFaultType | input | 2 | Gate fault kind, valid with gateFault |
| gateBusy | input | 1 | Gate currently owns the memory port |
| entryBase | input | 32 | Entry base word, valid with gateDone |
| memRdEn | output | 1 | Header read request |
| memAddr | output | 32 | Header read address |
| memRdData | input | 32 | Read data, valid the cycle after memRdEn |
| regWrEn | output | 1 | Capability register write strobe |
| regWrIdx | output | 4 | Target register index |
| regWrKind | output | 2 | Capability kind: 01 execute-only, 10 c-list |
| regWrBase | output | 32 | Capability base |
| regWrLimit | output | 32 | Capability limit |
| loadDone | output | 1 | Load completed |
| loadFault | output | 1 | Load failed |
| faultCode | output | 3 | Reason of the last fault, 0 if none |

## Verification
The stimulus covers capabilities of the wrong type, capabilities missing the execute permission, and valid ones. These show that the two capability checks are kept apart, and that the gate is started only when both pass. The gate outcomes include faults of several types and successes in which the gate stays busy for a varying number of cycles after done, which shows whether the block waits before it takes the memory port. The headers include typical sizes, the exact boundary cc = lump size - 2 (a code limit of 0), cc = 0, cc just past the boundary, and a maximum size with a high base that makes the c-list base wrap. Together these separate the two limit formulas, the scaled c-list base, and the header consistency fault. A second start pulse sent in the middle of a load checks that a busy block ignores it.

// File: rtl/lump_pkg.sv
package lump_pkg;
  localparam int CapW    = 32;
  localparam int AddrW   = 32;
  localparam int SizeW   = 16;
  localparam int CountW  = 8;
  localparam int RegIdxW = 4;
  localparam int CodeW   = 3;
  localparam int TypeW   = 4;
  localparam int HdrKeepW = SizeW + CountW;

  typedef enum logic [3:0] {
    StIdle, StCheckCap, StGateGo, StGateWait, StFetch,
    StHeader, StCheckHdr, StWrCode, StWrClist, StDone, StFault
  } state_t;

  typedef struct packed {
    logic             capLoad;
    logic             baseLoad;
    logic             hdrLoad;
    logic             faultLoad;
    logic             faultFromGate;
    logic [CodeW-1:0] faultCode;
    logic             selClist;
  } strobe_t;

  localparam logic [CodeW-1:0] FcNone   = 3'd0;
  localparam logic [CodeW-1:0] FcType   = 3'd1;
  localparam logic [CodeW-1:0] FcPerm   = 3'd2;
  localparam logic [CodeW-1:0] FcHeader = 3'd3;

  localparam logic [1:0] KindExec  = 2'b01;
  localparam logic [1:0] KindClist = 2'b10;
endpackage

// File: rtl/lump_ctrl.sv
module lump_ctrl
  import lump_pkg::*;
#(
  parameter int CODE_REG  = 14,
  parameter int CLIST_REG = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               gateDone,
  input  logic               gateFault,
  input  logic               gateBusy,
  input  logic               typeOk,
  input  logic               permOk,
  input  logic               hdrBad,
  output strobe_t            strb,
  output logic               gateStart,
  output logic               memRdEn,
  output logic               regWrEn,
  output logic [RegIdxW-1:0] regWrIdx,
  output logic [1:0]         regWrKind,
  output logic               loadDone,
  output logic               loadFault
);
  localparam logic [RegIdxW-1:0] CodeIdx  = RegIdxW'(CODE_REG);
  localparam logic [RegIdxW-1:0] ClistIdx = RegIdxW'(CLIST_REG);

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= StIdle;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      StIdle: if (startPulse) begin
        strb.capLoad = 1'b1;
        stateNext    = StCheckCap;
      end
      StCheckCap: begin
        if (!typeOk) begin
          strb.faultLoad = 1'b1;
          strb.faultCode = FcType;
          stateNext      = StFault;
        end else if (!permOk) begin
          strb.faultLoad = 1'b1;
          strb.faultCode = FcPerm;
          stateNext      = StFault;
        end else begin
          stateNext = StGateGo;
        end
      end
      StGateGo: stateNext = StGateWait;
      StGateWait: begin
        if (gateDone) begin
          strb.baseLoad = 1'b1;
          stateNext     = StFetch;
        end else if (gateFault) begin
          strb.faultLoad     = 1'b1;
          strb.faultFromGate = 1'b1;
          stateNext          = StFault;
        end
      end
      StFetch: if (!gateBusy) stateNext = StHeader;
      StHeader: begin
        strb.hdrLoad = 1'b1;
        stateNext    = StCheckHdr;
      end
      StCheckHdr: begin
        if (hdrBad) begin
          strb.faultLoad = 1'b1;
          strb.faultCode = FcHeader;
          stateNext      = StFault;
        end else begin
          stateNext = StWrCode;
        end
      end
      StWrCode: stateNext = StWrClist;
      StWrClist: begin
        strb.selClist = 1'b1;
        stateNext     = StDone;
      end
      StDone:  stateNext = StIdle;
      StFault: stateNext = StIdle;
      default: stateNext = StIdle;
    endcase
  end

  assign gateStart = (state == StGateGo);
  assign memRdEn   = (state == StFetch) && !gateBusy;
  assign regWrEn   = (state == StWrCode) || (state == StWrClist);
  assign regWrIdx  = (state == StWrClist) ? ClistIdx : CodeIdx;
  assign regWrKind = (state == StWrClist) ? KindClist :
                     (state == StWrCode)  ? KindExec  : 2'b00;
  assign loadDone  = (state == StDone);
  assign loadFault = (state == StFault);
endmodule

// File: rtl/lump_datapath.sv
module lump_datapath
  import lump_pkg::*;
#(
  parameter int INFORM_TYPE   = 5,
  parameter int EXEC_PERM_BIT = 27
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CapW-1:0]  capWord,
  input  logic [AddrW-1:0] entryBase,
  input  logic [1:0]       gateFaultType,
  input  logic [CapW-1:0]  memRdData,
  output logic             typeOk,
  output logic             permOk,
  output logic             hdrBad,
  output logic [CapW-1:0]  gateCap,
  output logic [AddrW-1:0] memAddr,
  output logic [AddrW-1:0] regWrBase,
  output logic [AddrW-1:0] regWrLimit,
  output logic [CodeW-1:0] faultCode
);
  localparam logic [TypeW-1:0] InformCode = TypeW'(INFORM_TYPE);

  logic [CapW-1:0]     capReg;
  logic [AddrW-1:0]    baseReg;
  logic [HdrKeepW-1:0] hdrReg;
  logic [CodeW-1:0]    faultReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg   <= '0;
      baseReg  <= '0;
      hdrReg   <= '0;
      faultReg <= FcNone;
    end else begin
      if (strb.capLoad) begin
        capReg   <= capWord;
        faultReg <= FcNone;
      end
      if (strb.baseLoad) baseReg <= entryBase;
      if (strb.hdrLoad)  hdrReg  <= memRdData[HdrKeepW-1:0];
      if (strb.faultLoad)
        faultReg <= strb.faultFromGate ? {1'b1, gateFaultType} : strb.faultCode;
    end
  end

  // upper header byte is not consumed by this block
  logic unusedHdrTop;
  assign unusedHdrTop = ^memRdData[CapW-1:HdrKeepW];

  logic [SizeW-1:0]  lumpSize;
  logic [CountW-1:0] clistCount;
  logic [SizeW-1:0]  codeWords;
  logic [SizeW:0]    countPlusTwo;

  assign lumpSize     = hdrReg[SizeW-1:0];
  assign clistCount   = hdrReg[HdrKeepW-1:SizeW];
  assign codeWords    = lumpSize - SizeW'(clistCount);
  assign countPlusTwo = (SizeW+1)'(clistCount) + (SizeW+1)'(2);

  assign typeOk = (capReg[CapW-1 -: TypeW] == InformCode);
  assign permOk = capReg[EXEC_PERM_BIT];
  assign hdrBad = (clistCount == '0) || (countPlusTwo > {1'b0, lumpSize});

  logic [AddrW-1:0] codeBase, codeLimit, clistBase, clistLimit;
  assign codeBase   = baseReg + AddrW'(4);
  assign codeLimit  = AddrW'(codeWords - SizeW'(2));
  assign clistBase  = baseReg + (AddrW'(codeWords) << 2);
  assign clistLimit = AddrW'(clistCount - CountW'(1));

  assign regWrBase  = strb.selClist ? clistBase  : codeBase;
  assign regWrLimit = strb.selClist ? clistLimit : codeLimit;
  assign gateCap    = capReg;
  assign memAddr    = baseReg;
  assign faultCode  = faultReg;
endmodule

// File: rtl/lump_loader.sv
module lump_loader
  import lump_pkg::*;
#(
  parameter int CODE_REG      = 14,
  parameter int CLIST_REG     = 6,
  parameter int INFORM_TYPE   = 5,
  parameter int EXEC_PERM_BIT = 27
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [CapW-1:0]    capWord,
  output logic               gateStart,
  output logic [CapW-1:0]    gateCap,
  input  logic               gateDone,
  input  logic               gateFault,
  input  logic [1:0]         gateFaultType,
  input  logic               gateBusy,
  input  logic [AddrW-1:0]   entryBase,
  output logic               memRdEn,
  output logic [AddrW-1:0]   memAddr,
  input  logic [CapW-1:0]    memRdData,
  output logic               regWrEn,
  output logic [RegIdxW-1:0] regWrIdx,
  output logic [1:0]         regWrKind,
  output logic [AddrW-1:0]   regWrBase,
  output logic [AddrW-1:0]   regWrLimit,
  output logic               loadDone,
  output logic               loadFault,
  output logic [CodeW-1:0]   faultCode
);
  strobe_t strb;
  logic    typeOk, permOk, hdrBad;

  lump_ctrl #(.CODE_REG(CODE_REG), .CLIST_REG(CLIST_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .gateDone(gateDone), .gateFault(gateFault), .gateBusy(gateBusy),
    .typeOk(typeOk), .permOk(permOk), .hdrBad(hdrBad),
    .strb(strb), .gateStart(gateStart), .memRdEn(memRdEn),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrKind(regWrKind),
    .loadDone(loadDone), .loadFault(loadFault)
  );

  lump_datapath #(.INFORM_TYPE(INFORM_TYPE), .EXEC_PERM_BIT(EXEC_PERM_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capWord(capWord),
    .entryBase(entryBase), .gateFaultType(gateFaultType), .memRdData(memRdData),
    .typeOk(typeOk), .permOk(permOk), .hdrBad(hdrBad),
    .gateCap(gateCap), .memAddr(memAddr),
    .regWrBase(regWrBase), .regWrLimit(regWrLimit), .faultCode(faultCode)
  );
endmodule

// File: rtl/lump_loader_checker.sv
module lump_loader_checker
  import lump_pkg::*;
#(
  parameter int CODE_REG  = 14,
  parameter int CLIST_REG = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               gateStart,
  input logic               gateBusy,
  input logic               memRdEn,
  input logic               regWrEn,
  input logic [RegIdxW-1:0] regWrIdx,
  input logic [1:0]         regWrKind,
  input logic               loadDone,
  input logic               loadFault,
  input logic [CodeW-1:0]   faultCode
);
  localparam logic [RegIdxW-1:0] CodeIdx  = RegIdxW'(CODE_REG);
  localparam logic [RegIdxW-1:0] ClistIdx = RegIdxW'(CLIST_REG);

  a_r6_bus_yield: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !gateBusy);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && loadFault));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  a_r12_fault_pulse: assert property (@(posedge clk) disable iff (!rstN)
    loadFault |=> !loadFault);

  a_r4_gate_pulse: assert property (@(posedge clk) disable iff (!rstN)
    gateStart |=> !gateStart);

  a_r8_clist_follows: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrIdx == CodeIdx && regWrKind == KindExec)
      |=> (regWrEn && regWrIdx == ClistIdx && regWrKind == KindClist));

  a_r9_done_after_writes: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrIdx == ClistIdx) |=> (loadDone && faultCode == FcNone));

  a_r10_no_write_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    loadFault |-> (!regWrEn && faultCode != FcNone));
endmodule

bind lump_loader lump_loader_checker #(.CODE_REG(CODE_REG), .CLIST_REG(CLIST_REG)) u_chk (
  .clk(clk), .rstN(rstN), .gateStart(gateStart), .gateBusy(gateBusy),
  .memRdEn(memRdEn), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
  .regWrKind(regWrKind), .loadDone(loadDone), .loadFault(loadFault),
  .faultCode(faultCode)
);

// File: tb/lump_loader_bench.sv
module lump_loader_bench;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 20000;

  typedef struct packed {
    logic [31:0] cap;
    logic        gateFails;
    logic [1:0]  gft;
    logic [31:0] base;
    logic [31:0] hdr;
    logic [3:0]  busy;
    logic        extraStart;
    logic [2:0]  expCode;
  } vec_t;

  localparam int NumVec = 9;
  localparam vec_t Vecs [NumVec] = '{
    '{32'h5800_1234, 1'b0, 2'd0, 32'h0000_1000, 32'h0A04_0040, 4'd0, 1'b0, 3'd0},
    '{32'h3800_0000, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 4'd0, 1'b0, 3'd1},
    '{32'h5000_0077, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 4'd0, 1'b0, 3'd2},
    '{32'h5C00_0001, 1'b1, 2'd2, 32'h0000_4000, 32'h0000_0000, 4'd0, 1'b0, 3'd6},
    '{32'h5800_00AA, 1'b0, 2'd0, 32'h2000_0000, 32'h000E_0010, 4'd3, 1'b0, 3'd0},
    '{32'h5800_0002, 1'b0, 2'd0, 32'h0000_8000, 32'h0000_0020, 4'd1, 1'b0, 3'd3},
    '{32'h5800_0003, 1'b0, 2'd0, 32'h0000_9000, 32'h001F_0020, 4'd0, 1'b0, 3'd3},
    '{32'h5FFF_FFFF, 1'b0, 2'd0, 32'hFFFF_0000, 32'hFF01_FFFF, 4'd2, 1'b1, 3'd0},
    '{32'h5800_0005, 1'b1, 2'd0, 32'h0000_0100, 32'h0000_0000, 4'd0, 1'b0, 3'd4}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] capWord = '0;
  logic        gateStart;
  logic [31:0] gateCap;
  logic        gateDone = 1'b0;
  logic        gateFault = 1'b0;
  logic [1:0]  gateFaultType = '0;
  logic        gateBusy = 1'b0;
  logic [31:0] entryBase = '0;
  logic        memRdEn;
  logic [31:0] memAddr;
  logic [31:0] memRdData = '0;
  logic        regWrEn;
  logic [3:0]  regWrIdx;
  logic [1:0]  regWrKind;
  logic [31:0] regWrBase;
  logic [31:0] regWrLimit;
  logic        loadDone;
  logic        loadFault;
  logic [2:0]  faultCode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  lump_loader u_lump_loader (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .capWord(capWord),
    .gateStart(gateStart), .gateCap(gateCap), .gateDone(gateDone),
    .gateFault(gateFault), .gateFaultType(gateFaultType), .gateBusy(gateBusy),
    .entryBase(entryBase), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrKind(regWrKind), .regWrBase(regWrBase), .regWrLimit(regWrLimit),
    .loadDone(loadDone), .loadFault(loadFault), .faultCode(faultCode)
  );

  always #(ClkPeriod/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WatchdogCycles) begin
      failures++;
      $display("FAIL watchdog: run exceeded %0d cycles", WatchdogCycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expBase(input logic [31:0] b, input logic [31:0] h, input bit clist);
    logic [31:0] sz, cc;
    sz = {16'h0, h[15:0]};
    cc = {24'h0, h[23:16]};
    return clist ? b + (sz - cc) * 4 : b + 32'd4;
  endfunction

  function automatic logic [31:0] expLimit(input logic [31:0] h, input bit clist);
    logic [31:0] sz, cc;
    sz = {16'h0, h[15:0]};
    cc = {24'h0, h[23:16]};
    return clist ? cc - 1 : sz - cc - 2;
  endfunction

  task automatic checkIdle(input string tag);
    check(!gateStart && !memRdEn && !regWrEn && !loadDone && !loadFault, tag,
          {27'h0, gateStart, memRdEn, regWrEn, loadDone, loadFault}, 32'h0);
  endtask

  task automatic runVec(input vec_t v, input int n);
    bit seenGate = 0, seenMem = 0, finished = 0, hdrPending = 0, extraPending = 0;
    int gateCnt = 0, busyRem = 0, nWr = 0, gateCyc = -1, doneCyc = -1;
    logic [3:0]  wIdx [2];
    logic [1:0]  wKind [2];
    logic [31:0] wBase [2];
    logic [31:0] wLim [2];
    int          wCyc [2];
    bit gotDone = 0, gotFault = 0;
    logic [2:0] gotCode = '0;
    @(negedge clk);
    capWord = v.cap;
    startPulse = 1'b1;
    for (int i = 0; i < 60 && !finished; i++) begin
      @(negedge clk);
      startPulse = extraPending;
      capWord = extraPending ? 32'h3000_0000 : 32'h0;
      extraPending = 0;
      gateDone = 1'b0;
      gateFault = 1'b0;
      if (gateCnt > 0) begin
        gateCnt--;
        if (gateCnt == 0) begin
          if (v.gateFails) gateFault = 1'b1;
          else             gateDone = 1'b1;
          gateFaultType = v.gft;
          entryBase = v.base;
          busyRem = int'(v.busy);
        end
      end else if (busyRem > 0) begin
        busyRem--;
      end
      gateBusy = (gateCnt > 0) || (busyRem > 0);
      memRdData = hdrPending ? v.hdr : 32'hA5A5_A5A5;
      hdrPending = 0;
      #1;
      if (gateStart) begin
        seenGate = 1;
        gateCyc = i;
        check(gateCap == v.cap, $sformatf("R4 vec%0d gateCap", n), gateCap, v.cap);
        gateCnt = 3;
        if (v.extraStart) extraPending = 1;
      end
      if (memRdEn) begin
        seenMem = 1;
        hdrPending = 1;
        check(memAddr == v.base, $sformatf("R6 vec%0d memAddr", n), memAddr, v.base);
        check(!gateBusy, $sformatf("R6 vec%0d read while busy", n), {31'h0, gateBusy}, 32'h0);
      end
      if (regWrEn) begin
        if (nWr < 2) begin
          wIdx[nWr] = regWrIdx; wKind[nWr] = regWrKind;
          wBase[nWr] = regWrBase; wLim[nWr] = regWrLimit; wCyc[nWr] = i;
        end
        nWr++;
      end
      if (loadDone || loadFault) begin
        finished = 1;
        gotDone = loadDone;
        gotFault = loadFault;
        gotCode = faultCode;
        doneCyc = i;
      end
    end
    gateBusy = 1'b0;
    if (v.expCode == 3'd0) begin
      check(gotDone && !gotFault && gotCode == 3'd0, $sformatf("R9 vec%0d done", n),
            {28'h0, gotDone, gotCode}, 32'h8);
      check(gateCyc == 1, $sformatf("R4 vec%0d gate timing", n), gateCyc, 1);
      check(nWr == 2, $sformatf("R8 vec%0d write count", n), nWr, 2);
      if (nWr == 2) begin
        check(wIdx[0] == 4'd14 && wKind[0] == 2'b01, $sformatf("R7 vec%0d code reg/kind", n),
              {wIdx[0], wKind[0]}, {4'd14, 2'b01});
        check(wBase[0] == expBase(v.base, v.hdr, 0), $sformatf("R7 vec%0d code base", n),
              wBase[0], expBase(v.base, v.hdr, 0));
        check(wLim[0] == expLimit(v.hdr, 0), $sformatf("R7 vec%0d code limit", n),
              wLim[0], expLimit(v.hdr, 0));
        check(wIdx[1] == 4'd6 && wKind[1] == 2'b10 && wCyc[1] == wCyc[0] + 1,
              $sformatf("R8 vec%0d clist reg/kind/cycle", n), {wIdx[1], wKind[1]}, {4'd6, 2'b10});
        check(wBase[1] == expBase(v.base, v.hdr, 1), $sformatf("R8 vec%0d clist base", n),
              wBase[1], expBase(v.base, v.hdr, 1));
        check(wLim[1] == expLimit(v.hdr, 1), $sformatf("R8 vec%0d clist limit", n),
              wLim[1], expLimit(v.hdr, 1));
        check(doneCyc == wCyc[1] + 1, $sformatf("R9 vec%0d done timing", n), doneCyc, wCyc[1] + 1);
      end
      if (v.extraStart)
        check(gotDone, $sformatf("R11 vec%0d second start ignored", n), {31'h0, gotDone}, 32'h1);
    end else begin
      check(gotFault && !gotDone && gotCode == v.expCode, $sformatf("vec%0d fault code", n),
            {28'h0, gotFault, gotCode}, {28'h0, 1'b1, v.expCode});
      check(nWr == 0, $sformatf("R10 vec%0d no writes on fault", n), nWr, 0);
      if (v.expCode == 3'd1)
        check(!seenGate, $sformatf("R2 vec%0d no gate start", n), {31'h0, seenGate}, 32'h0);
      if (v.expCode == 3'd2)
        check(!seenGate, $sformatf("R3 vec%0d no gate start", n), {31'h0, seenGate}, 32'h0);
      if (v.expCode >= 3'd4)
        check(!seenMem, $sformatf("R5 vec%0d no memory read", n), {31'h0, seenMem}, 32'h0);
      if (v.expCode == 3'd3)
        check(seenMem, $sformatf("R10 vec%0d header was read", n), {31'h0, seenMem}, 32'h1);
    end
    @(negedge clk);
    #1;
    checkIdle($sformatf("R9 vec%0d idle after end", n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checkIdle("R1 reset outputs");
    check(faultCode == 3'd0, "R1 reset faultCode", faultCode, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    checkIdle("R1 after reset release");

    for (int k = 0; k < NumVec; k++) runVec(Vecs[k], k);

    // R11: start pulse with a bad capability while busy is dropped entirely
    runVec('{32'h5800_0010, 1'b0, 2'd0, 32'h0000_0400, 32'h0302_0008, 4'd1, 1'b1, 3'd0}, 100);
    // R10: exact fit boundary cc = size - 2 already covered; cc = size - 1 with size 2
    runVec('{32'h5800_0011, 1'b0, 2'd0, 32'h0000_0500, 32'h0001_0002, 4'd0, 1'b0, 3'd3}, 101);
    // R5: gate fault of type 3
    runVec('{32'h5800_0012, 1'b1, 2'd3, 32'h0000_0600, 32'h0000_0000, 4'd0, 1'b0, 3'd7}, 102);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule